// File: doc/BRIEF.md
# Operate-Format Integer Execute Unit

This block executes single 32-bit operate instructions for a 64-bit RISC integer core. Each accepted instruction word is decoded into an operation, two operands are read from a 32 x 64-bit register file, the result is computed, and the result is written back to the destination register. The second operand comes either from a register or from an 8-bit unsigned literal held in the instruction. The supported operations are add, scaled subtract, and, or, xor, left shift, arithmetic right shift, truncated multiply, and a family of conditional moves. A conditional move writes only when a test of the first operand against zero holds.

An instruction is presented with `insn_valid` high for one clock. The register file is updated at that same rising edge. In the following cycle `done` is high for one cycle, and `illegal` is raised with it if the opcode and function pair was not recognised. Back-to-back instructions are accepted every cycle, and a dependent instruction sees the value its predecessor wrote. A combinational debug read port shows the contents of any register.

Top module: `opx_exec_unit`

## Requirements
- R1: After reset every register reads zero on the debug port, and `done` and `illegal` are low.
- R2: Instruction fields are opcode [31:26], first source A [25:21], second source B [20:16], literal select [12], function [11:5] and destination [4:0]. Opcode 0x10 with function 0x20 writes A + B modulo 2^64 (for example, 0x42110401 adds r16 and r17 into r1).
- R3: When bit 12 is 1, bits [20:13] are zero-extended to 64 bits and used in place of register B (for example, 0x42009410 adds literal 4 to r16 into r16).
- R4: Opcode 0x10 with function 0x2B writes 4*A - B modulo 2^64.
- R5: Opcode 0x11 with functions 0x00, 0x20 and 0x40 writes A and B, A or B, and A xor B respectively.
- R6: Opcode 0x12 with function 0x39 writes A shifted left, and with function 0x3C writes A shifted right with sign fill. Only B[5:0] is used as the shift amount.
- R7: Opcode 0x13 with function 0x20 writes the low 64 bits of A * B.
- R8: Opcode 0x11 conditional moves copy B into the destination only when their test on A holds, and leave it unchanged otherwise. The function codes are 0x24 (A == 0), 0x26 (A != 0), 0x44 (A < 0), 0x46 (A >= 0), 0x64 (A <= 0), 0x66 (A > 0), 0x14 (A[0] set) and 0x16 (A[0] clear), with signed comparisons.
- R9: Register 31 always reads zero, both as a source and on the debug port, and writes to it are discarded.
- R10: Any other opcode or function pair raises `illegal` together with `done` and writes no register.
- R11: `done` is high in exactly the cycle after each cycle in which `insn_valid` is high, and the next instruction reads the value the previous one wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Operate-format instruction |
| done | output | 1 | Completion pulse, one cycle after acceptance |
| illegal | output | 1 | Unrecognised opcode or function; valid with `done` |
| dbg_addr | input | 5 | Debug read register index |
| dbg_data | output | 64 | Debug read data, combinational |

## Verification
A wrong decode or operand selection corrupts the destination register. This shows up on the debug port in the cycle after `done`, and it shows up again in every later result that reads that register. A wrong write-enable decision appears as a changed register after an illegal word, a failed conditional move or a write to register 31. It can be seen as soon as the debug port is pointed at that register. A wrong completion flag appears as a missing, extra or mislabelled `done`/`illegal` pulse one cycle after the instruction was presented.

// File: rtl/opx_pkg.sv
package opx_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned LIT_W  = 8;

  localparam logic [5:0] OPC_INTA = 6'h10;
  localparam logic [5:0] OPC_INTL = 6'h11;
  localparam logic [5:0] OPC_INTS = 6'h12;
  localparam logic [5:0] OPC_INTM = 6'h13;

  typedef enum logic [3:0] {
    OP_ADD, OP_S4SUB, OP_AND, OP_OR, OP_XOR, OP_CMOV, OP_SLL, OP_SRA, OP_MUL
  } opx_op_e;

  typedef enum logic [2:0] {
    CC_EQ, CC_NE, CC_GT, CC_GE, CC_LT, CC_LE, CC_LBC, CC_LBS
  } opx_cc_e;

  typedef struct packed {
    logic              legal;
    opx_op_e           op;
    opx_cc_e           cc;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] rc;
    logic              use_lit;
    logic [LIT_W-1:0]  lit;
  } opx_dec_t;

  function automatic opx_dec_t opx_decode_word(input logic [INSN_W-1:0] w);
    opx_dec_t d;
    logic [5:0] opc;
    logic [6:0] fn;
    opc       = w[31:26];
    fn        = w[11:5];
    d.ra      = w[25:21];
    d.rb      = w[20:16];
    d.rc      = w[4:0];
    d.use_lit = w[12];
    d.lit     = w[20:13];
    d.legal   = 1'b1;
    d.op      = OP_ADD;
    d.cc      = CC_EQ;
    unique case (opc)
      OPC_INTA: begin
        if (fn == 7'h20)      d.op = OP_ADD;
        else if (fn == 7'h2B) d.op = OP_S4SUB;
        else                  d.legal = 1'b0;
      end
      OPC_INTL: begin
        case (fn)
          7'h00: d.op = OP_AND;
          7'h20: d.op = OP_OR;
          7'h40: d.op = OP_XOR;
          7'h24: begin d.op = OP_CMOV; d.cc = CC_EQ;  end
          7'h26: begin d.op = OP_CMOV; d.cc = CC_NE;  end
          7'h44: begin d.op = OP_CMOV; d.cc = CC_LT;  end
          7'h46: begin d.op = OP_CMOV; d.cc = CC_GE;  end
          7'h64: begin d.op = OP_CMOV; d.cc = CC_LE;  end
          7'h66: begin d.op = OP_CMOV; d.cc = CC_GT;  end
          7'h14: begin d.op = OP_CMOV; d.cc = CC_LBS; end
          7'h16: begin d.op = OP_CMOV; d.cc = CC_LBC; end
          default: d.legal = 1'b0;
        endcase
      end
      OPC_INTS: begin
        if (fn == 7'h39)      d.op = OP_SLL;
        else if (fn == 7'h3C) d.op = OP_SRA;
        else                  d.legal = 1'b0;
      end
      OPC_INTM: begin
        if (fn == 7'h20) d.op = OP_MUL;
        else             d.legal = 1'b0;
      end
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
(
  input  logic [INSN_W-1:0] insn_word,
  output opx_dec_t          dec
);
  always_comb dec = opx_decode_word(insn_word);
endmodule

// File: rtl/opx_alu.sv
module opx_alu
  import opx_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  opx_op_e           op,
  input  opx_cc_e           cc,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  output logic [XLEN-1:0]   result,
  output logic              cond_ok
);
  localparam int unsigned SHW = $clog2(XLEN);

  function automatic logic [XLEN-1:0] f_s4sub(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return (a << 2) - b;
  endfunction

  function automatic logic [XLEN-1:0] f_sll(input logic [XLEN-1:0] a, input logic [SHW-1:0] s);
    return a << s;
  endfunction

  function automatic logic [XLEN-1:0] f_sra(input logic [XLEN-1:0] a, input logic [SHW-1:0] s);
    return $signed(a) >>> s;
  endfunction

  function automatic logic [XLEN-1:0] f_mul(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    logic [XLEN-1:0] p;
    p = a * b;
    return p;
  endfunction

  function automatic logic f_test(input opx_cc_e c, input logic [XLEN-1:0] a);
    logic zero, neg;
    zero = (a == '0);
    neg  = a[XLEN-1];
    case (c)
      CC_EQ:   return zero;
      CC_NE:   return !zero;
      CC_GT:   return !neg && !zero;
      CC_GE:   return !neg;
      CC_LT:   return neg;
      CC_LE:   return neg || zero;
      CC_LBC:  return !a[0];
      CC_LBS:  return a[0];
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    cond_ok = f_test(cc, opnd_a);
    case (op)
      OP_ADD:   result = opnd_a + opnd_b;
      OP_S4SUB: result = f_s4sub(opnd_a, opnd_b);
      OP_AND:   result = opnd_a & opnd_b;
      OP_OR:    result = opnd_a | opnd_b;
      OP_XOR:   result = opnd_a ^ opnd_b;
      OP_SLL:   result = f_sll(opnd_a, opnd_b[SHW-1:0]);
      OP_SRA:   result = f_sra(opnd_a, opnd_b[SHW-1:0]);
      OP_MUL:   result = f_mul(opnd_a, opnd_b);
      default:  result = opnd_b;
    endcase
  end
endmodule

// File: rtl/opx_regfile.sv
module opx_regfile #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  output logic [XLEN-1:0]         rdata_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [XLEN-1:0]         rdata_b,
  input  logic [$clog2(NREG)-1:0] raddr_d,
  output logic [XLEN-1:0]         rdata_d
);
  localparam int unsigned AW       = $clog2(NREG);
  localparam int unsigned ZERO_IDX = NREG - 1;

  logic [XLEN-1:0] ent [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ent[i] <= '0;
    end else if (we && (waddr != AW'(ZERO_IDX))) begin
      ent[waddr] <= wdata;
    end
  end

  function automatic logic [XLEN-1:0] rd(input logic [AW-1:0] idx);
    if (idx == AW'(ZERO_IDX)) return '0;
    return ent[idx];
  endfunction

  always_comb begin
    rdata_a = rd(raddr_a);
    rdata_b = rd(raddr_b);
    rdata_d = rd(raddr_d);
  end
endmodule

// File: rtl/opx_exec_unit.sv
module opx_exec_unit
  import opx_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    insn_valid,
  input  logic [INSN_W-1:0]       insn_word,
  output logic                    done,
  output logic                    illegal,
  input  logic [$clog2(NREG)-1:0] dbg_addr,
  output logic [XLEN-1:0]         dbg_data
);
  localparam int unsigned AW       = $clog2(NREG);
  localparam int unsigned ZERO_IDX = NREG - 1;

  opx_dec_t        dec;
  logic [XLEN-1:0] val_a, val_rb, opnd_b, alu_res;
  logic            cond_ok;
  logic            wr_fire;
  logic [AW-1:0]   wr_idx;

  opx_decode u_dec (
    .insn_word (insn_word),
    .dec       (dec)
  );

  opx_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_fire),
    .waddr   (wr_idx),
    .wdata   (alu_res),
    .raddr_a (AW'(dec.ra)),
    .rdata_a (val_a),
    .raddr_b (AW'(dec.rb)),
    .rdata_b (val_rb),
    .raddr_d (dbg_addr),
    .rdata_d (dbg_data)
  );

  assign opnd_b = dec.use_lit ? {{(XLEN-LIT_W){1'b0}}, dec.lit} : val_rb;

  opx_alu #(.XLEN(XLEN)) u_alu (
    .op      (dec.op),
    .cc      (dec.cc),
    .opnd_a  (val_a),
    .opnd_b  (opnd_b),
    .result  (alu_res),
    .cond_ok (cond_ok)
  );

  assign wr_idx  = AW'(dec.rc);
  assign wr_fire = insn_valid && dec.legal
                   && ((dec.op != OP_CMOV) || cond_ok)
                   && (wr_idx != AW'(ZERO_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= insn_valid;
      illegal <= insn_valid && !dec.legal;
    end
  end
endmodule

// File: rtl/opx_exec_chk.sv
module opx_exec_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    insn_valid,
  input logic                    done,
  input logic                    illegal,
  input logic                    wr_fire,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [$clog2(NREG)-1:0] dbg_addr,
  input logic [XLEN-1:0]         dbg_data
);
  localparam int unsigned AW = $clog2(NREG);

  // R11
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> done);

  // R11
  done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !done);

  // R10
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R10
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && wr_fire |=> !illegal);

  // R9
  no_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_idx != AW'(NREG - 1)));

  // R9
  zero_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == AW'(NREG - 1)) |-> (dbg_data == '0));

  // R11
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> insn_valid);
endmodule

bind opx_exec_unit opx_exec_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .done       (done),
  .illegal    (illegal),
  .wr_fire    (wr_fire),
  .wr_idx     (wr_idx),
  .dbg_addr   (dbg_addr),
  .dbg_data   (dbg_data)
);

// File: tb/opx_exec_unit_test.sv
`timescale 1ns/1ps
module opx_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic        done, illegal;
  logic [4:0]  dbg_addr = '0;
  logic [63:0] dbg_data;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m [32];
  bit exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  opx_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .done(done), .illegal(illegal), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  function automatic logic [31:0] w_rr(input logic [5:0] opc, input logic [6:0] fn,
                                       input logic [4:0] a, input logic [4:0] b, input logic [4:0] c);
    return {opc, a, b, 3'b000, 1'b0, fn, c};
  endfunction

  function automatic logic [31:0] w_rl(input logic [5:0] opc, input logic [6:0] fn,
                                       input logic [4:0] a, input logic [7:0] lit, input logic [4:0] c);
    return {opc, a, lit, 1'b1, fn, c};
  endfunction

  function automatic logic [63:0] rd(input logic [4:0] i);
    return (i == 5'd31) ? 64'd0 : m[i];
  endfunction

  // Independent reference: decides legality, write and value from the word.
  task automatic model(input logic [31:0] w, output bit legal);
    logic [63:0] a, b, v;
    logic [12:0] key;
    bit wr;
    int sh;
    a = rd(w[25:21]);
    b = w[12] ? {56'd0, w[20:13]} : rd(w[20:16]);
    key = {w[31:26], w[11:5]};
    sh = int'(b % 64);
    legal = 1'b1; wr = 1'b1; v = '0;
    case (key)
      {6'h10, 7'h20}: v = a + b;
      {6'h10, 7'h2B}: v = a * 4 - b;
      {6'h11, 7'h00}: v = a & b;
      {6'h11, 7'h20}: v = a | b;
      {6'h11, 7'h40}: v = a ^ b;
      {6'h12, 7'h39}: v = a << sh;
      {6'h12, 7'h3C}: v = 64'($signed(a) >>> sh);
      {6'h13, 7'h20}: v = a * b;
      {6'h11, 7'h24}: begin v = b; wr = (a == 0); end
      {6'h11, 7'h26}: begin v = b; wr = (a != 0); end
      {6'h11, 7'h44}: begin v = b; wr = ($signed(a) < 0); end
      {6'h11, 7'h46}: begin v = b; wr = ($signed(a) >= 0); end
      {6'h11, 7'h64}: begin v = b; wr = ($signed(a) <= 0); end
      {6'h11, 7'h66}: begin v = b; wr = ($signed(a) > 0); end
      {6'h11, 7'h14}: begin v = b; wr = (a % 2 == 1); end
      {6'h11, 7'h16}: begin v = b; wr = (a % 2 == 0); end
      default: begin legal = 1'b0; wr = 1'b0; end
    endcase
    if (wr && w[4:0] != 5'd31) m[w[4:0]] = v;
  endtask

  // Driver: presents one word and pushes the expected completion flag.
  task automatic issue(input logic [31:0] w, input string tag);
    bit legal;
    @(negedge clk);
    insn_valid = 1'b1;
    insn_word  = w;
    model(w, legal);
    exp_q.push_back(!legal);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    insn_valid = 1'b0;
    insn_word  = '0;
  endtask

  task automatic check_reg(input logic [4:0] i, input string tag);
    dbg_addr = i;
    #1;
    n_cmp++;
    if (dbg_data !== rd(i)) begin
      n_bad++;
      $display("FAIL %s: r%0d actual %h expected %h", tag, i, dbg_data, rd(i));
    end
  endtask

  // Monitor: pops one expected item per completion pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11: done actual 1 expected 0");
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (illegal !== e) begin
          n_bad++;
          $display("FAIL %s: illegal actual %b expected %b", t, illegal, e);
        end
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [6:0] CMOV_FN [8] = '{7'h24, 7'h26, 7'h44, 7'h46, 7'h64, 7'h66, 7'h14, 7'h16};

  initial begin
    for (int i = 0; i < 32; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    n_cmp++;
    if (done !== 1'b0 || illegal !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: done/illegal actual %b%b expected 00", done, illegal);
    end
    check_reg(5'd0, "R1");
    check_reg(5'd16, "R1");
    check_reg(5'd30, "R1");

    // Build r16 = 0xABC and r17 = 0x123 with literals and shifts
    issue(w_rl(6'h11, 7'h20, 5'd31, 8'hAB, 5'd16), "R3");
    issue(w_rl(6'h12, 7'h39, 5'd16, 8'd4, 5'd16), "R6");
    issue(w_rl(6'h11, 7'h20, 5'd16, 8'h0C, 5'd16), "R5");
    issue(w_rl(6'h11, 7'h20, 5'd31, 8'h12, 5'd17), "R3");
    issue(w_rl(6'h12, 7'h39, 5'd17, 8'd4, 5'd17), "R6");
    issue(w_rl(6'h10, 7'h20, 5'd17, 8'h03, 5'd17), "R11");
    idle();
    check_reg(5'd16, "R11");
    check_reg(5'd17, "R11");
    issue(32'h42110401, "R2");
    idle();
    check_reg(5'd1, "R2");
    issue(32'h42009410, "R3");
    issue(w_rl(6'h10, 7'h20, 5'd31, 8'hFF, 5'd2), "R3");
    idle();
    check_reg(5'd16, "R3");
    check_reg(5'd2, "R3");

    // R4 scaled subtract, including a wrap to all ones
    issue(w_rr(6'h10, 7'h2B, 5'd17, 5'd17, 5'd18), "R4");
    issue(w_rl(6'h10, 7'h2B, 5'd1, 8'hFF, 5'd19), "R4");
    issue(w_rl(6'h10, 7'h2B, 5'd31, 8'd1, 5'd3), "R4");
    idle();
    check_reg(5'd18, "R4");
    check_reg(5'd19, "R4");
    check_reg(5'd3, "R4");

    // R5 logic operations
    issue(w_rr(6'h11, 7'h00, 5'd16, 5'd17, 5'd5), "R5");
    issue(w_rr(6'h11, 7'h20, 5'd16, 5'd17, 5'd6), "R5");
    issue(w_rr(6'h11, 7'h40, 5'd3, 5'd1, 5'd7), "R5");
    idle();
    check_reg(5'd5, "R5");
    check_reg(5'd6, "R5");
    check_reg(5'd7, "R5");

    // R6 shifts: top bit, sign fill, amounts above 63 masked
    issue(w_rl(6'h11, 7'h20, 5'd31, 8'd1, 5'd4), "R6");
    issue(w_rl(6'h12, 7'h39, 5'd4, 8'd63, 5'd4), "R6");
    issue(w_rl(6'h12, 7'h3C, 5'd4, 8'd4, 5'd8), "R6");
    issue(w_rl(6'h12, 7'h39, 5'd1, 8'h41, 5'd9), "R6");
    issue(w_rl(6'h11, 7'h20, 5'd31, 8'h44, 5'd10), "R6");
    issue(w_rr(6'h12, 7'h3C, 5'd4, 5'd10, 5'd11), "R6");
    issue(w_rl(6'h12, 7'h3C, 5'd17, 8'd4, 5'd12), "R6");
    idle();
    check_reg(5'd4, "R6");
    check_reg(5'd8, "R6");
    check_reg(5'd9, "R6");
    check_reg(5'd11, "R6");
    check_reg(5'd12, "R6");

    // R7 multiply, with truncation
    issue(w_rr(6'h13, 7'h20, 5'd1, 5'd17, 5'd13), "R7");
    issue(w_rr(6'h13, 7'h20, 5'd4, 5'd4, 5'd14), "R7");
    issue(w_rr(6'h13, 7'h20, 5'd3, 5'd3, 5'd15), "R7");
    issue(w_rr(6'h13, 7'h20, 5'd8, 5'd16, 5'd20), "R7");
    idle();
    check_reg(5'd13, "R7");
    check_reg(5'd14, "R7");
    check_reg(5'd15, "R7");
    check_reg(5'd20, "R7");

    // R8 every condition against zero, positive, negative, odd and even sources
    foreach (CMOV_FN[k]) begin
      logic [4:0] srcs [5];
      srcs = '{5'd31, 5'd1, 5'd3, 5'd2, 5'd16};
      foreach (srcs[j]) begin
        issue(w_rl(6'h11, 7'h20, 5'd31, 8'h5A, 5'd21), "R8");
        issue(w_rl(6'h11, CMOV_FN[k], srcs[j], 8'hC3, 5'd21), "R8");
        issue(w_rr(6'h11, CMOV_FN[k], srcs[j], 5'd13, 5'd22), "R8");
        idle();
        check_reg(5'd21, "R8");
        check_reg(5'd22, "R8");
      end
    end

    // R9 register 31 as destination and source
    issue(w_rr(6'h10, 7'h20, 5'd1, 5'd2, 5'd31), "R9");
    issue(w_rr(6'h10, 7'h20, 5'd31, 5'd31, 5'd23), "R9");
    issue(w_rr(6'h11, 7'h24, 5'd31, 5'd1, 5'd31), "R9");
    idle();
    check_reg(5'd31, "R9");
    check_reg(5'd23, "R9");

    // R10 unknown opcodes and functions write nothing
    issue(w_rr(6'h14, 7'h20, 5'd16, 5'd17, 5'd1), "R10");
    issue(w_rr(6'h10, 7'h7F, 5'd16, 5'd17, 5'd1), "R10");
    issue(w_rl(6'h11, 7'h21, 5'd16, 8'h01, 5'd2), "R10");
    issue(w_rr(6'h12, 7'h3A, 5'd16, 5'd17, 5'd5), "R10");
    issue(w_rr(6'h13, 7'h00, 5'd16, 5'd17, 5'd6), "R10");
    idle();
    check_reg(5'd1, "R10");
    check_reg(5'd2, "R10");
    check_reg(5'd5, "R10");
    check_reg(5'd6, "R10");

    // R11 no completion while idle
    repeat (3) begin
      @(negedge clk);
      n_cmp++;
      if (done !== 1'b0) begin
        n_bad++;
        $display("FAIL R11: idle done actual %b expected 0", done);
      end
    end
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: pending completions actual %0d expected 0", exp_q.size());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule